// File: doc/BRIEF.md
# DMA Command Token Parser

This block sits between a processor's command port and a DMA engine. Command words arrive one per valid/ready handshake. Each header word holds an opcode and a channel number. Depending on the opcode bits, the parser collects the operand words that follow it. It keeps eight 32-bit configuration slots for each of 32 channels. When a transfer command has all its operands, the block presents one descriptor on its output handshake. The descriptor carries:

- the transfer attributes,
- both addresses and both variable flags,
- the channel's configuration, with the geometry taken from the header for fast transfers.

Moving data, bus mastering and data packing are left to later stages. This block only parses commands and holds channel state.

The FSM has nine states:

- `ST_IDLE`: expects a header.
- `ST_ARMED`: a run token was seen; the transfer header is expected.
- `ST_DST`, `ST_SRC`, `ST_DVAR`, `ST_SVAR`: collect the transfer operands.
- `ST_CFG`: takes the eight words of a full channel configuration.
- `ST_PVAL`: takes the value of a single-slot update.
- `ST_EMIT`: holds the descriptor until it is taken.

The transitions are:

- IDLE→CFG on a full-configuration header.
- IDLE→PVAL on a single-slot header.
- IDLE→ARMED on any other word.
- ARMED→DST on the transfer header.
- DST→SRC→DVAR.
- DVAR→EMIT for a clear transfer, DVAR→SVAR otherwise.
- SVAR→EMIT.
- CFG→IDLE after the eighth word.
- PVAL→IDLE.
- EMIT→IDLE on `out_ready`.

Top module: `dma_token_parser`

## Requirements
- R1: While `rst` is high at a clock edge, the parser returns to `ST_IDLE` and every configuration slot of every channel becomes zero. After reset, `in_ready`=1, `out_valid`=0 and `err_param`=0.
- R2: A header word decodes as follows:
  - opcode: bits 5..0
  - channel: bits 10..6
  - slot id: bits 14..11, used only by single-slot commands
  
  The descriptor's `out_chan` equals the transfer header's channel field.
- R3: A header with opcode bit5=1 and bit0=0 is a full configuration. The next eight words are stored in the channel's slots 0 to 7 in arrival order: setup, stride A, count/crop A, width A, stride B, count/crop B, width B, height. Slot k appears in `out_cfg[32k+31:32k]`.
- R4: A header with opcode bit5=1 and bit0=1 is a single-slot update. The one following word is written to the slot named by the slot id, for ids 0 to 7.
- R5: A single-slot update with slot id 8 to 15 consumes its value word and changes no slot. It sets `err_param`, which stays high until reset.
- R6: In `ST_IDLE`, a word with bit5=0 arms the parser and its other bits are ignored. The next word is the transfer header, whose bit5 is not examined. It is followed by the destination address, the source address or fill value, the destination-variable word and the source-variable word. A variable flag is bit 0 of its word. The descriptor is presented in the cycle after the last operand is accepted.
- R7: When opcode bit3 (clear) is set, the source-variable word is not expected, and `out_src_var` is 0.
- R8: The descriptor attributes are taken from the transfer opcode:
  - `out_fast` is bit0.
  - `out_check` is the inverse of bit1.
  - `out_dir_a2b` is bit2 (1 means A to B).
  - `out_clear` is bit3.
  - `out_ack_req` is 1 only when bits 4 and 1 are both 0.
- R9: For a fast transfer (bit0=1), three slots are replaced from the header, each zero-extended:
  - slot 3 by header bits 17..11
  - slot 6 by bits 25..18
  - slot 7 by bits 31..26
  
  The other slots come from storage, and the stored configuration is left unchanged.
- R10: While `out_valid` is high and `out_ready` low, `in_ready` is low and the descriptor holds steady. After the handshake, a new header is accepted.
- R11: Configuration writes to one channel leave every other channel's slots unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command word valid |
| in_ready | output | 1 | Parser accepts a word |
| in_data | input | 32 | Command word |
| out_valid | output | 1 | Descriptor valid |
| out_ready | input | 1 | Descriptor taken |
| out_chan | output | 5 | Channel of the transfer |
| out_dir_a2b | output | 1 | 1 = A to B, 0 = B to A |
| out_clear | output | 1 | Fill with value instead of copying |
| out_fast | output | 1 | Geometry came from the header |
| out_check | output | 1 | Completion sync check requested |
| out_ack_req | output | 1 | Acknowledge required |
| out_dst | output | 32 | Destination address |
| out_src | output | 32 | Source address or fill value |
| out_dst_var | output | 1 | Destination-is-variable flag |
| out_src_var | output | 1 | Source-is-variable flag |
| out_cfg | output | 256 | Eight effective configuration slots |
| err_param | output | 1 | Sticky unknown-slot-id flag |

## Verification
The bench builds the block with its default values: 32 channels and 32-bit words. This makes every channel number in the 5-bit header field reachable, including the highest channel 31. The fast-transfer fields at the top of the header can be driven with all bits set. Slot ids 8 to 15 are also reachable, so the error path is exercised next to the eight valid slots.

// File: rtl/dtp_pkg.sv
package dtp_pkg;
    localparam int OPC_W     = 6;
    localparam int CHAN_LSB  = 6;
    localparam int SLOT_LSB  = 11;
    localparam int SLOTID_W  = 4;
    localparam int N_SLOT    = 8;
    localparam int FHI_LSB   = 11;
    localparam int FHI_W     = 21;

    // opcode bit positions
    localparam int OB_FAST  = 0;
    localparam int OB_NOCHK = 1;
    localparam int OB_DIR   = 2;
    localparam int OB_CLR   = 3;
    localparam int OB_NOACK = 4;
    localparam int OB_CFG   = 5;

    // slot positions whose content a fast transfer replaces
    localparam int SLOT_WA  = 3;
    localparam int SLOT_WB  = 6;
    localparam int SLOT_HT  = 7;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ARMED, ST_DST, ST_SRC, ST_DVAR,
        ST_SVAR, ST_CFG, ST_PVAL, ST_EMIT
    } pst_t;
endpackage

// File: rtl/dtp_cfg_bank.sv
module dtp_cfg_bank #(
    parameter int N_CHAN = 32,
    parameter int N_SLOT = 8,
    parameter int W      = 32,
    localparam int CH_W  = $clog2(N_CHAN),
    localparam int SL_W  = $clog2(N_SLOT)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [CH_W-1:0]       wr_chan,
    input  logic [SL_W-1:0]       wr_slot,
    input  logic [W-1:0]          wr_data,
    input  logic [CH_W-1:0]       rd_chan,
    output logic [N_SLOT*W-1:0]   rd_cfg
);
    logic [W-1:0] slots [N_CHAN][N_SLOT];

    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst)
                    slots[c][s] <= '0;
                else if (wr_en && wr_chan == CH_W'(c) && wr_slot == SL_W'(s))
                    slots[c][s] <= wr_data;
            end
        end
    end

    for (genvar s = 0; s < N_SLOT; s++) begin : g_rd
        assign rd_cfg[s*W +: W] = slots[rd_chan][s];
    end
endmodule

// File: rtl/dtp_geom_mux.sv
module dtp_geom_mux
    import dtp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                  fast,
    input  logic [FHI_W-1:0]      fhi,
    input  logic [N_SLOT*W-1:0]   stored,
    output logic [N_SLOT*W-1:0]   eff
);
    logic [W-1:0] wa, wb, ht;
    assign wa = {{(W-7){1'b0}}, fhi[6:0]};
    assign wb = {{(W-8){1'b0}}, fhi[14:7]};
    assign ht = {{(W-6){1'b0}}, fhi[20:15]};

    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
        if (s == SLOT_WA) begin : g_wa
            assign eff[s*W +: W] = fast ? wa : stored[s*W +: W];
        end else if (s == SLOT_WB) begin : g_wb
            assign eff[s*W +: W] = fast ? wb : stored[s*W +: W];
        end else if (s == SLOT_HT) begin : g_ht
            assign eff[s*W +: W] = fast ? ht : stored[s*W +: W];
        end else begin : g_pass
            assign eff[s*W +: W] = stored[s*W +: W];
        end
    end
endmodule

// File: rtl/dma_token_parser.sv
module dma_token_parser
    import dtp_pkg::*;
#(
    parameter int TOK_W  = 32,
    parameter int N_CHAN = 32,
    localparam int CH_W  = $clog2(N_CHAN),
    localparam int SL_W  = $clog2(N_SLOT)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [TOK_W-1:0]        in_data,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [CH_W-1:0]         out_chan,
    output logic                    out_dir_a2b,
    output logic                    out_clear,
    output logic                    out_fast,
    output logic                    out_check,
    output logic                    out_ack_req,
    output logic [TOK_W-1:0]        out_dst,
    output logic [TOK_W-1:0]        out_src,
    output logic                    out_dst_var,
    output logic                    out_src_var,
    output logic [N_SLOT*TOK_W-1:0] out_cfg,
    output logic                    err_param
);
    pst_t                 state, nxt;
    logic [OPC_W-1:0]     opc_q;
    logic [CH_W-1:0]      chan_q;
    logic [SLOTID_W-1:0]  sid_q;
    logic [FHI_W-1:0]     fhi_q;
    logic [SL_W-1:0]      cnt_q;
    logic [TOK_W-1:0]     dst_q, src_q;
    logic                 dvar_q, svar_q, err_q;
    logic                 acc, wr_en, sid_ok;
    logic [SL_W-1:0]      wr_slot;
    logic [N_SLOT*TOK_W-1:0] stored;

    assign acc    = in_valid && in_ready;
    assign sid_ok = sid_q < SLOTID_W'(N_SLOT);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (acc) begin
                          if (!in_data[OB_CFG])     nxt = ST_ARMED;
                          else if (in_data[OB_FAST]) nxt = ST_PVAL;
                          else                       nxt = ST_CFG;
                      end
            ST_ARMED: if (acc) nxt = ST_DST;
            ST_DST:   if (acc) nxt = ST_SRC;
            ST_SRC:   if (acc) nxt = ST_DVAR;
            ST_DVAR:  if (acc) nxt = opc_q[OB_CLR] ? ST_EMIT : ST_SVAR;
            ST_SVAR:  if (acc) nxt = ST_EMIT;
            ST_CFG:   if (acc && cnt_q == SL_W'(N_SLOT-1)) nxt = ST_IDLE;
            ST_PVAL:  if (acc) nxt = ST_IDLE;
            ST_EMIT:  if (out_ready) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // operand capture
    always_ff @(posedge clk) begin
        if (rst) begin
            opc_q  <= '0;
            chan_q <= '0;
            sid_q  <= '0;
            fhi_q  <= '0;
            cnt_q  <= '0;
            dst_q  <= '0;
            src_q  <= '0;
            dvar_q <= 1'b0;
            svar_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (acc) begin
            unique case (state)
                ST_IDLE: begin
                    opc_q  <= in_data[OPC_W-1:0];
                    chan_q <= in_data[CHAN_LSB +: CH_W];
                    sid_q  <= in_data[SLOT_LSB +: SLOTID_W];
                    cnt_q  <= '0;
                end
                ST_ARMED: begin
                    opc_q  <= in_data[OPC_W-1:0];
                    chan_q <= in_data[CHAN_LSB +: CH_W];
                    fhi_q  <= in_data[FHI_LSB +: FHI_W];
                end
                ST_DST:  begin dst_q <= in_data; svar_q <= 1'b0; end
                ST_SRC:  src_q  <= in_data;
                ST_DVAR: dvar_q <= in_data[0];
                ST_SVAR: svar_q <= in_data[0];
                ST_CFG:  cnt_q  <= cnt_q + 1'b1;
                ST_PVAL: if (!sid_ok) err_q <= 1'b1;
                default: ;
            endcase
        end
    end

    assign wr_en   = acc && ((state == ST_CFG) || (state == ST_PVAL && sid_ok));
    assign wr_slot = (state == ST_CFG) ? cnt_q : sid_q[SL_W-1:0];

    dtp_cfg_bank #(.N_CHAN(N_CHAN), .N_SLOT(N_SLOT), .W(TOK_W)) bank_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_chan(chan_q),
        .wr_slot(wr_slot), .wr_data(in_data), .rd_chan(chan_q), .rd_cfg(stored)
    );

    dtp_geom_mux #(.W(TOK_W)) geom_i (
        .fast(opc_q[OB_FAST]), .fhi(fhi_q), .stored(stored), .eff(out_cfg)
    );

    // outputs
    always_comb begin
        in_ready    = (state != ST_EMIT);
        out_valid   = (state == ST_EMIT);
        out_chan    = chan_q;
        out_fast    = opc_q[OB_FAST];
        out_check   = !opc_q[OB_NOCHK];
        out_dir_a2b = opc_q[OB_DIR];
        out_clear   = opc_q[OB_CLR];
        out_ack_req = !opc_q[OB_NOACK] && !opc_q[OB_NOCHK];
        out_dst     = dst_q;
        out_src     = src_q;
        out_dst_var = dvar_q;
        out_src_var = svar_q;
        err_param   = err_q;
    end
endmodule

// File: rtl/dtp_checker.sv
module dtp_checker #(
    parameter int TOK_W = 32,
    parameter int CH_W  = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_clear,
    input logic             out_src_var,
    input logic             out_ack_req,
    input logic             out_check,
    input logic [TOK_W-1:0] out_dst,
    input logic [TOK_W-1:0] out_src,
    input logic [CH_W-1:0]  out_chan,
    input logic             err_param
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready && !err_param));

    // R10
    pend_block_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_dst)
            && $stable(out_src) && $stable(out_chan)));

    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_param |=> err_param);

    // R7
    clr_novar_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_clear) |-> !out_src_var);

    // R8
    ack_needs_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ack_req) |-> out_check);
endmodule

bind dma_token_parser dtp_checker #(.TOK_W(TOK_W), .CH_W(CH_W)) chk_i (
    .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_clear(out_clear), .out_src_var(out_src_var),
    .out_ack_req(out_ack_req), .out_check(out_check), .out_dst(out_dst),
    .out_src(out_src), .out_chan(out_chan), .err_param(err_param)
);

// File: tb/dma_token_parser_tb_top.sv
`timescale 1ns/1ps
module dma_token_parser_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [31:0]  in_data = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [4:0]   out_chan;
    logic         out_dir_a2b, out_clear, out_fast, out_check, out_ack_req;
    logic [31:0]  out_dst, out_src;
    logic         out_dst_var, out_src_var;
    logic [255:0] out_cfg;
    logic         err_param;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] m_cfg [32][8];
    logic        exp_err = 1'b0;

    always #2.5 clk = ~clk;

    dma_token_parser dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_chan(out_chan), .out_dir_a2b(out_dir_a2b), .out_clear(out_clear),
        .out_fast(out_fast), .out_check(out_check), .out_ack_req(out_ack_req),
        .out_dst(out_dst), .out_src(out_src), .out_dst_var(out_dst_var),
        .out_src_var(out_src_var), .out_cfg(out_cfg), .err_param(err_param)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_slot(input int ch, input int s,
                                             input bit fast, input logic [31:0] hdr);
        if (fast && s == 3) return {25'd0, hdr[17:11]};
        if (fast && s == 6) return {24'd0, hdr[25:18]};
        if (fast && s == 7) return {26'd0, hdr[31:26]};
        return m_cfg[ch][s];
    endfunction

    task automatic send(input logic [31:0] t);
        @(negedge clk);
        in_data  = t;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_cfg(input int ch);
        logic [31:0] v;
        send({$urandom} & 32'hFFFF_8000 | (32'(ch) << 6) | 32'h20);
        for (int s = 0; s < 8; s++) begin
            v = $urandom;
            send(v);
            m_cfg[ch][s] = v;
        end
    endtask

    task automatic do_param(input int ch, input int sid, input logic [31:0] v);
        send((32'(sid) << 11) | (32'(ch) << 6) | 32'h21);
        send(v);
        if (sid < 8) m_cfg[ch][sid] = v;
        else         exp_err = 1'b1;
    endtask

    // opc: 5-bit opcode (bit5 zero); hi: header bits 31..11
    task automatic do_xfer(input int ch, input logic [4:0] opc, input logic [20:0] hi,
                           input logic [31:0] dst, input logic [31:0] src,
                           input bit dv, input bit sv, input int stall);
        logic [31:0] hdr;
        bit clr, sv_exp;
        hdr = {hi, 5'(ch), 1'b0, opc};
        clr = opc[3];
        sv_exp = clr ? 1'b0 : sv;
        send({$urandom} & 32'hFFFF_FFDF);           // R6 arming word
        send(hdr);
        send(dst);
        send(src);
        send({31'($urandom), dv});
        if (!clr) send({31'($urandom), sv});
        chk(out_valid === 1'b1, "R6 descriptor valid", 64'(out_valid), 64'd1);
        chk(out_chan === 5'(ch), "R2 channel field", 64'(out_chan), 64'(ch));
        chk(out_dst === dst && out_src === src, "R6 addresses",
            {out_dst, out_src}, {dst, src});
        chk(out_dst_var === dv, "R6 dst var", 64'(out_dst_var), 64'(dv));
        chk(out_src_var === sv_exp, "R7 src var", 64'(out_src_var), 64'(sv_exp));
        chk({out_fast, out_check, out_dir_a2b, out_clear, out_ack_req} ===
            {opc[0], ~opc[1], opc[2], opc[3], ~opc[4] & ~opc[1]},
            "R8 attributes",
            64'({out_fast, out_check, out_dir_a2b, out_clear, out_ack_req}),
            64'({opc[0], ~opc[1], opc[2], opc[3], ~opc[4] & ~opc[1]}));
        for (int s = 0; s < 8; s++)
            chk(out_cfg[s*32 +: 32] === exp_slot(ch, s, opc[0], hdr),
                opc[0] ? "R9 effective slot" : "R3 stored slot",
                64'(out_cfg[s*32 +: 32]), 64'(exp_slot(ch, s, opc[0], hdr)));
        chk(err_param === exp_err, "R5 error flag", 64'(err_param), 64'(exp_err));
        for (int k = 0; k < stall; k++) begin
            @(negedge clk);
            chk(out_valid === 1'b1 && in_ready === 1'b0 && out_dst === dst,
                "R10 hold under backpressure",
                {30'd0, out_valid, in_ready, out_dst}, {30'd0, 2'b10, dst});
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(out_valid === 1'b0 && in_ready === 1'b1, "R10 released",
            64'({out_valid, in_ready}), 64'b01);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int c = 0; c < 32; c++)
            for (int s = 0; s < 8; s++) m_cfg[c][s] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(in_ready === 1'b1 && out_valid === 1'b0 && err_param === 1'b0,
            "R1 reset outputs", 64'({in_ready, out_valid, err_param}), 64'b100);
        // R1 zero config visible; R8 plain acked read
        do_xfer(5, 5'b00000, 21'h1FFFFF, 32'h1000_0000, 32'h2000_0004, 1'b1, 1'b0, 0);
        // R3 full config on the extreme channels, R11 isolation
        do_cfg(31);
        do_xfer(31, 5'b00100, '0, 32'hA, 32'hB, 1'b0, 1'b1, 0);
        do_xfer(0, 5'b00010, '0, 32'hC, 32'hD, 1'b1, 1'b1, 0);
        do_cfg(0);
        do_xfer(31, 5'b10000, '0, 32'hE, 32'hF, 1'b0, 1'b0, 0);
        // R4 single-slot update
        do_param(31, 2, 32'hDEAD_BEEF);
        do_param(31, 7, 32'h0000_0011);
        do_xfer(31, 5'b00000, '0, 32'h1, 32'h2, 1'b0, 1'b0, 0);
        // R5 unknown slot id: consumed, nothing written, flag sticky
        do_param(31, 9, 32'h5555_5555);
        do_param(31, 15, 32'hAAAA_AAAA);
        do_xfer(31, 5'b00000, '0, 32'h3, 32'h4, 1'b1, 1'b0, 0);
        // R7 clear transfers, both directions
        do_xfer(12, 5'b01000, '0, 32'h40, 32'h0, 1'b1, 1'b1, 0);
        do_xfer(12, 5'b11110, '0, 32'h44, 32'h7F, 1'b0, 1'b1, 0);
        // R9 fast transfer with all header fields set, then stored view unchanged
        do_xfer(31, 5'b00001, 21'h1FFFFF, 32'h50, 32'h60, 1'b1, 1'b1, 0);
        do_xfer(31, 5'b00000, '0, 32'h70, 32'h80, 1'b0, 1'b0, 0);
        // R10 backpressure
        do_xfer(7, 5'b00101, 21'h0ABCDE, 32'h90, 32'hA0, 1'b1, 1'b0, 4);
        // random mix
        for (int i = 0; i < 120; i++) begin
            int op;
            int ch;
            op = int'($urandom_range(0, 5));
            ch = int'($urandom_range(0, 31));
            if (op == 0) do_cfg(ch);
            else if (op == 1) do_param(ch, int'($urandom_range(0, 8)), $urandom);
            else do_xfer(ch, 5'($urandom), 21'($urandom), $urandom, $urandom,
                         1'($urandom), 1'($urandom), int'($urandom_range(0, 2)));
        end
        // R1 reset clears everything again
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int c = 0; c < 32; c++)
            for (int s = 0; s < 8; s++) m_cfg[c][s] = '0;
        exp_err = 1'b0;
        chk(err_param === 1'b0, "R1 error cleared", 64'(err_param), 64'd0);
        do_xfer(31, 5'b00000, '0, 32'h5, 32'h6, 1'b0, 1'b0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule